// File: doc/BRIEF.md
# Parallel I/O Port with Input Pulldown Control

This block is one memory-mapped 8-bit parallel port for a small microcontroller. Software reaches it over a simple synchronous register bus. A direction register decides, pin by pin, whether the pad driver is on. A data latch holds the value driven on output pins. A pulldown-inhibit register switches off the weak pulldown on pins that are used as inputs. The pad's input level passes through a two-flop synchronizer. A read of the port address then mixes latch bits for output pins with synchronized pin levels for input pins.

Pulldowns only ever act on input pins, and only on the pins that have a pulldown device (selected by a parameter mask; by default pins 5..0). A strap input, sampled while reset is asserted, picks the start-up state of the pulldowns. When the strap is 0, every pulldown is on after reset. When it is 1, every pulldown stays off until software first writes the pulldown-inhibit register.

Top module: `gpio_pd_port`

## Requirements
- R1: While reset is held and after it is released, the direction register and data latch are 0: padOe = 0x00, padOut = 0x00, and a read of the direction register (address 0x05) returns 0x00.
- R2: Writing the direction register (address 0x05) sets padOe to the written byte from the next clock edge. A 1 bit drives that pin and a 0 bit leaves it as a high-impedance input.
- R3: A read of the port address 0x01 returns, per bit, the latch bit where the direction bit is 1 and the synchronized pin level where it is 0.
- R4: A write to address 0x01 always updates the data latch, whatever the direction bits are. padOut shows the latch, but a pin set as input keeps padOe low and still reads back its pin level.
- R5: A change on padIn appears in port reads only after two rising clock edges: it is unchanged after one edge and visible after the second.
- R6: The pulldown-inhibit register sits at address 0x11. A 1 bit turns that pin's pulldown off and a 0 bit leaves it on. Only bits 5..0 exist; pins 7 and 6 have no pulldown device, so padPdEn[7:6] are always 0.
- R7: A pin whose direction bit is 1 never has padPdEn set.
- R8: Reset clears the pulldown-inhibit bits. If swpdiCfg is 1 during reset, every padPdEn bit is 0 after reset until the first write to address 0x11. If it is 0, padPdEn = 0x3F right after reset.
- R9: A read of address 0x11, or of any address other than 0x01 and 0x05, returns 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| swpdiCfg | input | 1 | Pulldown start-up strap, sampled during reset |
| busAddr | input | 5 | Register address |
| busWe | input | 1 | Write enable |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data for busAddr (combinational) |
| padIn | input | 8 | Pad input levels (asynchronous) |
| padOe | output | 8 | Per-pin output-driver enable |
| padOut | output | 8 | Per-pin output value |
| padPdEn | output | 8 | Per-pin pulldown enable |

## Verification
The bench goes after the mixed-direction port read. A design that swaps the per-bit selection, or that always returns the latch, gives a wrong byte when the pins are half inputs and half outputs. It writes the latch while the pins are inputs: a design that gates the write with direction loses the value, and one that turns the driver on shows up on padOe. It steps padIn one edge at a time to catch a synchronizer with too few or too many stages. It also resets with the strap set to each value and then writes the inhibit register. This catches pulldowns that come up on, stay stuck off, ignore the direction bits, or appear on pins 7 and 6.

// File: rtl/gpio_pd_pkg.sv
package gpio_pd_pkg;
  typedef enum logic [1:0] {RD_ZERO, RD_PORT, RD_DIR} rdSel_e;

  typedef struct packed {
    logic   wrLatch;
    logic   wrDir;
    logic   wrInhibit;
    rdSel_e rdSel;
  } ctlStrobe_t;
endpackage

// File: rtl/gpio_pd_sync.sv
module gpio_pd_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] stage1;
  logic [WIDTH-1:0] stage2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      stage2 <= '0;
    end else begin
      stage1 <= din;
      stage2 <= stage1;
    end
  end

  assign dout = stage2;
endmodule

// File: rtl/gpio_pd_ctrl.sv
module gpio_pd_ctrl
  import gpio_pd_pkg::*;
#(
  parameter int              ADDR_W    = 5,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 5'h01,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 5'h05,
  parameter logic [ADDR_W-1:0] INH_ADDR  = 5'h11
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output ctlStrobe_t        strobes
);
  logic hitData;
  logic hitDir;
  logic hitInh;

  assign hitData = (busAddr == DATA_ADDR);
  assign hitDir  = (busAddr == DIR_ADDR);
  assign hitInh  = (busAddr == INH_ADDR);

  always_comb begin
    strobes.wrLatch   = busWe && hitData;
    strobes.wrDir     = busWe && hitDir;
    strobes.wrInhibit = busWe && hitInh;
    if (hitData)     strobes.rdSel = RD_PORT;
    else if (hitDir) strobes.rdSel = RD_DIR;
    else             strobes.rdSel = RD_ZERO;
  end
endmodule

// File: rtl/gpio_pd_dp.sv
module gpio_pd_dp
  import gpio_pd_pkg::*;
#(
  parameter int               PIN_W   = 8,
  parameter logic [PIN_W-1:0] PD_MASK = 8'h3F
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             swpdiCfg,
  input  ctlStrobe_t       strobes,
  input  logic [PIN_W-1:0] busWdata,
  input  logic [PIN_W-1:0] padIn,
  output logic [PIN_W-1:0] rdData,
  output logic [PIN_W-1:0] padOe,
  output logic [PIN_W-1:0] padOut,
  output logic [PIN_W-1:0] padPdEn
);
  logic [PIN_W-1:0] latchReg;
  logic [PIN_W-1:0] dirReg;
  logic [PIN_W-1:0] inhReg;
  logic             forceOff;
  logic [PIN_W-1:0] pinSync;
  logic [1:0]       ageCnt;

  gpio_pd_sync #(.WIDTH(PIN_W)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (padIn),
    .dout (pinSync)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchReg <= '0;
      dirReg   <= '0;
      inhReg   <= '0;
      forceOff <= swpdiCfg;
      ageCnt   <= '0;
    end else begin
      if (strobes.wrLatch) latchReg <= busWdata;
      if (strobes.wrDir)   dirReg   <= busWdata;
      if (strobes.wrInhibit) begin
        inhReg   <= busWdata & PD_MASK;
        forceOff <= 1'b0;
      end
      if (ageCnt != 2'd3) ageCnt <= ageCnt + 2'd1;
    end
  end

  assign padOe  = dirReg;
  assign padOut = latchReg;

  for (genvar i = 0; i < PIN_W; i++) begin : g_pd
    if (PD_MASK[i]) begin : g_dev
      assign padPdEn[i] = !dirReg[i] && !inhReg[i] && !forceOff;
    end else begin : g_none
      assign padPdEn[i] = 1'b0;
    end
  end

  always_comb begin
    unique case (strobes.rdSel)
      RD_PORT: rdData = (latchReg & dirReg) | (pinSync & ~dirReg);
      RD_DIR:  rdData = dirReg;
      default: rdData = '0;
    endcase
  end

  // R4: latch captures any data-address write
  assert_latch_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrLatch |=> padOut == $past(busWdata));

  // R2: direction write drives output enables
  assert_dir_write_R2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrDir |=> padOe == $past(busWdata));

  // R5: two-stage synchronizer latency
  assert_sync_delay_R5: assert property (@(posedge clk) disable iff (!rstN)
    (ageCnt == 2'd3) |-> pinSync == $past(padIn, 2));

  // R8: first inhibit write releases the reset-forced disable
  assert_force_clear_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrInhibit |=> !forceOff);
endmodule

// File: rtl/gpio_pd_port.sv
module gpio_pd_port
  import gpio_pd_pkg::*;
#(
  parameter int                PIN_W     = 8,
  parameter int                ADDR_W    = 5,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 5'h01,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 5'h05,
  parameter logic [ADDR_W-1:0] INH_ADDR  = 5'h11,
  parameter logic [PIN_W-1:0]  PD_MASK   = 8'h3F
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              swpdiCfg,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic [PIN_W-1:0]  busWdata,
  output logic [PIN_W-1:0]  busRdata,
  input  logic [PIN_W-1:0]  padIn,
  output logic [PIN_W-1:0]  padOe,
  output logic [PIN_W-1:0]  padOut,
  output logic [PIN_W-1:0]  padPdEn
);
  ctlStrobe_t strobes;

  gpio_pd_ctrl #(
    .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR), .INH_ADDR(INH_ADDR)
  ) u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .strobes (strobes)
  );

  gpio_pd_dp #(.PIN_W(PIN_W), .PD_MASK(PD_MASK)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .swpdiCfg (swpdiCfg),
    .strobes  (strobes),
    .busWdata (busWdata),
    .padIn    (padIn),
    .rdData   (busRdata),
    .padOe    (padOe),
    .padOut   (padOut),
    .padPdEn  (padPdEn)
  );

  // R7: driven pins never pulled down
  assert_no_pd_on_output_R7: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & padPdEn) == '0);

  // R6: pins without a pulldown device stay off
  assert_no_pd_unimpl_R6: assert property (@(posedge clk) disable iff (!rstN)
    (padPdEn & ~PD_MASK) == '0);

  // R9: inhibit register is write-only
  assert_inh_reads_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == INH_ADDR) |-> busRdata == '0);
endmodule

// File: tb/sim_gpio_pd_port.sv
`timescale 1ns/1ps
module sim_gpio_pd_port;
  localparam logic [4:0] A_DATA = 5'h01;
  localparam logic [4:0] A_DIR  = 5'h05;
  localparam logic [4:0] A_INH  = 5'h11;
  localparam int K_RD = 0, K_OE = 1, K_OUT = 2, K_PD = 3;

  typedef struct {
    int        kind;
    logic [7:0] exp;
    string     req;
  } expItem_t;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       swpdiCfg = 1'b0;
  logic [4:0] busAddr = '0;
  logic       busWe = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic [7:0] padIn = '0;
  logic [7:0] padOe, padOut, padPdEn;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  expItem_t sbq[$];

  always #2.5 clk = ~clk;

  gpio_pd_port u0 (
    .clk(clk), .rstN(rstN), .swpdiCfg(swpdiCfg), .busAddr(busAddr),
    .busWe(busWe), .busWdata(busWdata), .busRdata(busRdata), .padIn(padIn),
    .padOe(padOe), .padOut(padOut), .padPdEn(padPdEn)
  );

  // monitor: pops expected items and compares against the outputs
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      expItem_t it;
      logic [7:0] act;
      it = sbq.pop_front();
      case (it.kind)
        K_RD:    act = busRdata;
        K_OE:    act = padOe;
        K_OUT:   act = padOut;
        default: act = padPdEn;
      endcase
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s kind=%0d actual=0x%02h expected=0x%02h", it.req, it.kind, act, it.exp);
      end
    end
  end

  task automatic expectVal(int kind, logic [4:0] addr, logic [7:0] exp, string req);
    expItem_t it;
    busAddr = addr;
    it.kind = kind; it.exp = exp; it.req = req;
    sbq.push_back(it);
    @(negedge clk); #1;
  endtask

  task automatic writeReg(logic [4:0] addr, logic [7:0] data);
    @(posedge clk); #1;
    busAddr = addr; busWdata = data; busWe = 1'b1;
    @(posedge clk); #1;
    busWe = 1'b0;
  endtask

  task automatic doReset(logic strap);
    @(posedge clk); #1;
    swpdiCfg = strap;
    rstN = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    expectVal(K_OE, A_DATA, 8'h00, "R1 oe during reset");
    @(posedge clk); #1;
    rstN = 1'b1;
  endtask

  initial begin
    doReset(1'b0);
    expectVal(K_OE,  A_DATA, 8'h00, "R1 oe after reset");
    expectVal(K_OUT, A_DATA, 8'h00, "R1 latch after reset");
    expectVal(K_RD,  A_DIR,  8'h00, "R1 dir readback");
    expectVal(K_PD,  A_DATA, 8'h3F, "R8 strap0 pulldowns on");
    expectVal(K_RD,  A_DATA, 8'h00, "R3 read all-input pins low");

    // latch write while all pins are inputs
    writeReg(A_DATA, 8'hA5);
    expectVal(K_OUT, A_DATA, 8'hA5, "R4 latch written on inputs");
    expectVal(K_OE,  A_DATA, 8'h00, "R4 driver stays off");
    expectVal(K_RD,  A_DATA, 8'h00, "R4 input read shows pin");

    padIn = 8'hF0;
    repeat (3) @(posedge clk);
    #1;
    writeReg(A_DIR, 8'h0F);
    expectVal(K_OE, A_DATA, 8'h0F, "R2 oe follows dir");
    expectVal(K_RD, A_DATA, 8'hF5, "R3 mixed read");
    expectVal(K_PD, A_DATA, 8'h30, "R7 outputs have no pulldown");
    expectVal(K_RD, A_DIR,  8'h0F, "R2 dir readback");

    // synchronizer latency
    @(posedge clk); #1;
    padIn = 8'h3A;
    expectVal(K_RD, A_DATA, 8'hF5, "R5 no edge yet");
    @(posedge clk); #1;
    expectVal(K_RD, A_DATA, 8'hF5, "R5 one edge");
    @(posedge clk); #1;
    expectVal(K_RD, A_DATA, 8'h35, "R5 two edges");

    // pulldown inhibit
    writeReg(A_INH, 8'h10);
    expectVal(K_PD, A_DATA, 8'h20, "R6 inhibit bit4");
    expectVal(K_RD, A_INH,  8'h00, "R9 inhibit reads zero");
    expectVal(K_RD, 5'h02,  8'h00, "R9 unmapped reads zero");
    writeReg(A_DIR, 8'h00);
    expectVal(K_PD, A_DATA, 8'h2F, "R6 inputs pulled except inhibited");
    writeReg(A_INH, 8'hFF);
    expectVal(K_PD, A_DATA, 8'h00, "R6 all inhibited, 7:6 none");
    writeReg(A_INH, 8'h00);
    expectVal(K_PD, A_DATA, 8'h3F, "R6 pins 7 and 6 have no pulldown");
    writeReg(A_INH, 8'h3F);

    // strap 1: pulldowns forced off until inhibit write
    doReset(1'b1);
    expectVal(K_PD, A_DATA, 8'h00, "R8 strap1 pulldowns off");
    expectVal(K_OE, A_DATA, 8'h00, "R8 strap1 all inputs");
    writeReg(A_DIR, 8'h01);
    expectVal(K_PD, A_DATA, 8'h00, "R8 still forced off");
    writeReg(A_INH, 8'h00);
    expectVal(K_PD, A_DATA, 8'h3E, "R8 released by inhibit write");

    // strap 0 reset clears inhibit bits
    writeReg(A_INH, 8'h3F);
    doReset(1'b0);
    expectVal(K_PD, A_DATA, 8'h3F, "R8 reset clears inhibit");

    @(posedge clk); #1;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule